// File: doc/BRIEF.md
# Multichannel DMA Configuration Register Bank

This block is the memory-mapped register file that sits between a CPU and a multichannel DMA. The CPU reaches it through a simple slave port with chip select, read and write enables, a word address and 32-bit data. The address space is split into 16-word windows, one for each receive channel. Each window holds that channel's buffer address, its remote bus address, its word amount, a current buffer pointer and a received-word count. Window 0 also holds the shared registers: a combined status and configuration word, a channel-armed mask, an interrupt register, the transmit settings and the last unmatched bus address seen by the receive engine.

The receive and transmit engines read their settings from parallel output vectors. They report progress back through single-cycle strobes: a pointer and count update, a channel-done event, an unmatched-address capture and a transmit-done event. These strobes are always accepted in the cycle they are raised, so the block has no ready pins and applies no back-pressure. The CPU port has no wait states either. Writes take effect at the clock edge where they are sampled. Read data appears one cycle after the read is sampled and then holds until the next read.

A write to a channel's amount register arms that channel. Completion and unmatched-address events set bits in the interrupt register. Those bits raise a level interrupt when the configuration word enables them.

Top module: `dma_cfg_regbank`

## Requirements
- R1: Receive channel c occupies word addresses c*16 to c*16+15. Its buffer address is at offset 0, its remote address at offset 1, its amount at offset 2, its current pointer at offset 3 and its received-word count at offset 6. Buffer address and remote address read back what the CPU last wrote.
- R2: The shared registers exist only in window 0: control/status at offset 4, armed mask at 5, interrupt at 7, transmit registers at 8 to 11 and the unmatched address at 12. Window-0 offsets 13 to 15, and offsets 4, 5 and 7 to 15 of every other window, read as zero and ignore writes.
- R3: A read sampled with chip select and read enable high returns the addressed word on `cfg_rdata` one cycle later. `cfg_rdata` holds its value in cycles that follow no read.
- R4: CPU writes to the current pointer (offset 3), the received-word count (offset 6) and the unmatched address (offset 12) have no effect.
- R5: A CPU write to channel c's amount register sets bit c of the armed mask. In the same edge it loads the current pointer from the channel's buffer address and clears the received-word count.
- R6: An engine update strobe for channel c loads its current pointer and its received-word count. If a CPU amount write to the same channel falls in the same cycle, the amount write wins.
- R7: A channel-done strobe for channel c sets interrupt bit c and clears armed bit c. Writing 1 to a bit of the armed mask clears that bit.
- R8: Writing 1 to an interrupt register bit clears it. A set event in the same cycle wins over the clear.
- R9: An unmatched-address strobe stores the address, which reads back at offset 12, and sets interrupt bit 31.
- R10: `irq_o` is high when any channel interrupt bit is set and configuration bit 1 is 1, or when interrupt bit 31 is set and configuration bit 2 is 1.
- R11: Writing 1 to configuration bit 0 while idle pulses `tx_start_o` for the one cycle after the write and sets status bit 16 (busy). Busy stays set until `tx_done`. A start written while busy is ignored. Bit 0 always reads as 0, and the read word at offset 4 is {15'b0, busy, cfg[15:1], 1'b0}.
- R12: The transmit buffer address (8), amount (9), command (10) and destination address (11) read back and drive the transmit outputs. All amount registers keep only their low AMT_W (16) bits, and the upper bits read as zero.
- R13: After reset all registers, `cfg_rdata`, `irq_o`, `tx_start_o` and the armed mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cs | input | 1 | Slave chip select |
| cfg_we | input | 1 | Write enable |
| cfg_re | input | 1 | Read enable |
| cfg_addr | input | ADDR_W (7) | Word address: channel window in the upper bits, offset in the low 4 bits |
| cfg_wdata | input | DW (32) | Write data |
| cfg_rdata | output | DW (32) | Registered read data |
| irq_o | output | 1 | Level interrupt to the CPU |
| rx_buf_addr_o | output | NCH*DW | Per-channel buffer addresses, channel 0 in the low bits |
| rx_bus_addr_o | output | NCH*DW | Per-channel remote addresses |
| rx_amount_o | output | NCH*AMT_W | Per-channel word amounts |
| rx_ptr_o | output | NCH*DW | Per-channel current pointers |
| rx_armed_o | output | NCH | Armed mask |
| rx_upd_valid | input | 1 | Engine pointer/count update strobe |
| rx_upd_chan | input | CH_W (3) | Channel for the update |
| rx_upd_ptr | input | DW | New current pointer |
| rx_upd_count | input | AMT_W | New received-word count |
| rx_done_valid | input | 1 | Channel-done strobe |
| rx_done_chan | input | CH_W | Channel that finished |
| unm_valid | input | 1 | Unmatched-address strobe |
| unm_addr | input | DW | Unmatched bus address |
| tx_buf_addr_o | output | DW | Transmit buffer address |
| tx_amount_o | output | AMT_W | Transmit word amount |
| tx_cmd_o | output | DW | Transmit command |
| tx_dest_o | output | DW | Transmit destination address |
| tx_start_o | output | 1 | One-cycle transmit start pulse |
| tx_done | input | 1 | Transmit-complete strobe |

## Verification
The hardest situations to reach are same-cycle collisions between the CPU and the engines. One is an amount write meeting an engine pointer update for the same channel. The other is a write-one-to-clear of an interrupt bit meeting a new set event for that bit. The bench brings each about by raising the engine strobe on the same falling edge at which it presents the CPU write, so that both are sampled at one rising edge. It then reads the pointer, count and interrupt words back through the slave port. The busy interlock is reached by writing a second start before pulsing `tx_done` and observing that no second pulse appears.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int WIN_W = 4;
  // per-channel window offsets
  localparam logic [3:0] OFS_BUF    = 4'd0;
  localparam logic [3:0] OFS_BUSA   = 4'd1;
  localparam logic [3:0] OFS_AMT    = 4'd2;
  localparam logic [3:0] OFS_PTR    = 4'd3;
  localparam logic [3:0] OFS_CNT    = 4'd6;
  // shared offsets, window 0 only
  localparam logic [3:0] OFS_CTRL   = 4'd4;
  localparam logic [3:0] OFS_ARMED  = 4'd5;
  localparam logic [3:0] OFS_IRQ    = 4'd7;
  localparam logic [3:0] OFS_TXBUF  = 4'd8;
  localparam logic [3:0] OFS_TXAMT  = 4'd9;
  localparam logic [3:0] OFS_TXCMD  = 4'd10;
  localparam logic [3:0] OFS_TXDEST = 4'd11;
  localparam logic [3:0] OFS_UNM    = 4'd12;
  // bit positions
  localparam int CFG_GO      = 0;
  localparam int CFG_RX_IE   = 1;
  localparam int CFG_UNM_IE  = 2;
  localparam int UNM_IRQ_BIT = 31;
endpackage

// File: rtl/dma_rx_chan_regs.sv
module dma_rx_chan_regs
  import dma_cfg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_ofs,
  input  logic [DW-1:0]    wdata,
  input  logic             upd_en,
  input  logic [DW-1:0]    upd_ptr,
  input  logic [AMT_W-1:0] upd_cnt,
  input  logic             done_en,
  input  logic             armed_clr,
  output logic [DW-1:0]    buf_q,
  output logic [DW-1:0]    busa_q,
  output logic [AMT_W-1:0] amt_q,
  output logic [DW-1:0]    ptr_q,
  output logic [AMT_W-1:0] cnt_q,
  output logic             armed_q
);
  logic arm;
  assign arm = wr_en && (wr_ofs == OFS_AMT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      busa_q  <= '0;
      amt_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_en && wr_ofs == OFS_BUF)  buf_q  <= wdata;
      if (wr_en && wr_ofs == OFS_BUSA) busa_q <= wdata;
      if (arm) amt_q <= wdata[AMT_W-1:0];
      // CPU arming wins over engine progress
      if (arm) begin
        ptr_q <= buf_q;
        cnt_q <= '0;
      end else if (upd_en) begin
        ptr_q <= upd_ptr;
        cnt_q <= upd_cnt;
      end
      if (arm) armed_q <= 1'b1;
      else if (done_en || armed_clr) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_tx_ctrl_regs.sv
module dma_tx_ctrl_regs
  import dma_cfg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_ofs,
  input  logic [DW-1:0]    wdata,
  input  logic             tx_done,
  output logic [DW-1:0]    tx_buf_q,
  output logic [AMT_W-1:0] tx_amt_q,
  output logic [DW-1:0]    tx_cmd_q,
  output logic [DW-1:0]    tx_dest_q,
  output logic [15:0]      cfg_o,
  output logic             busy_q,
  output logic             start_q
);
  logic [15:1] cfg_q;
  logic        go;

  assign go    = wr_en && (wr_ofs == OFS_CTRL) && wdata[CFG_GO];
  assign cfg_o = {cfg_q, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf_q  <= '0;
      tx_amt_q  <= '0;
      tx_cmd_q  <= '0;
      tx_dest_q <= '0;
      cfg_q     <= '0;
      busy_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      if (wr_en && wr_ofs == OFS_TXBUF)  tx_buf_q  <= wdata;
      if (wr_en && wr_ofs == OFS_TXAMT)  tx_amt_q  <= wdata[AMT_W-1:0];
      if (wr_en && wr_ofs == OFS_TXCMD)  tx_cmd_q  <= wdata;
      if (wr_en && wr_ofs == OFS_TXDEST) tx_dest_q <= wdata;
      if (wr_en && wr_ofs == OFS_CTRL)   cfg_q     <= wdata[15:1];
      start_q <= go && !busy_q;
      if (go && !busy_q) busy_q <= 1'b1;
      else if (tx_done)  busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_cfg_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_valid,
  input  logic [CH_W-1:0] done_chan,
  input  logic            unm_valid,
  input  logic [DW-1:0]   unm_addr,
  input  logic            clr_en,
  input  logic [31:0]     clr_mask,
  input  logic            rx_ie,
  input  logic            unm_ie,
  output logic [31:0]     irq_bits,
  output logic [DW-1:0]   unm_q,
  output logic            irq_o
);
  localparam logic [31:0] CH_MASK = (32'h1 << NCH) - 32'h1;
  localparam logic [31:0] VMASK   = CH_MASK | (32'h1 << UNM_IRQ_BIT);

  logic [31:0] set_vec;
  logic [31:0] clr_vec;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NCH; i++)
      if (done_valid && done_chan == CH_W'(i)) set_vec[i] = 1'b1;
    if (unm_valid) set_vec[UNM_IRQ_BIT] = 1'b1;
    clr_vec = clr_en ? clr_mask : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_bits <= '0;
      unm_q    <= '0;
    end else begin
      // set wins over a same-cycle clear
      irq_bits <= ((irq_bits & ~clr_vec) | set_vec) & VMASK;
      if (unm_valid) unm_q <= unm_addr;
    end
  end

  assign irq_o = (rx_ie && |(irq_bits & CH_MASK)) || (unm_ie && irq_bits[UNM_IRQ_BIT]);
endmodule

// File: rtl/dma_cfg_regbank.sv
module dma_cfg_regbank
  import dma_cfg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 16,
  parameter int NCH   = 8,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + WIN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_cs,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  output logic               irq_o,
  output logic [NCH*DW-1:0]  rx_buf_addr_o,
  output logic [NCH*DW-1:0]  rx_bus_addr_o,
  output logic [NCH*AMT_W-1:0] rx_amount_o,
  output logic [NCH*DW-1:0]  rx_ptr_o,
  output logic [NCH-1:0]     rx_armed_o,
  input  logic               rx_upd_valid,
  input  logic [CH_W-1:0]    rx_upd_chan,
  input  logic [DW-1:0]      rx_upd_ptr,
  input  logic [AMT_W-1:0]   rx_upd_count,
  input  logic               rx_done_valid,
  input  logic [CH_W-1:0]    rx_done_chan,
  input  logic               unm_valid,
  input  logic [DW-1:0]      unm_addr,
  output logic [DW-1:0]      tx_buf_addr_o,
  output logic [AMT_W-1:0]   tx_amount_o,
  output logic [DW-1:0]      tx_cmd_o,
  output logic [DW-1:0]      tx_dest_o,
  output logic               tx_start_o,
  input  logic               tx_done
);
  logic [CH_W-1:0] win;
  logic [3:0]      ofs;
  logic            wr, win0, win_ok;

  assign win    = cfg_addr[ADDR_W-1:WIN_W];
  assign ofs    = cfg_addr[WIN_W-1:0];
  assign wr     = cfg_cs && cfg_we;
  assign win0   = (win == '0);
  assign win_ok = (int'(win) < NCH);

  logic [DW-1:0]    buf_a  [NCH];
  logic [DW-1:0]    busa_a [NCH];
  logic [AMT_W-1:0] amt_a  [NCH];
  logic [DW-1:0]    ptr_a  [NCH];
  logic [AMT_W-1:0] cnt_a  [NCH];
  logic [NCH-1:0]   armed;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c, upd_c, done_c, clr_c;
    assign wr_c   = wr && (win == CH_W'(c));
    assign upd_c  = rx_upd_valid && (rx_upd_chan == CH_W'(c));
    assign done_c = rx_done_valid && (rx_done_chan == CH_W'(c));
    assign clr_c  = wr && win0 && (ofs == OFS_ARMED) && cfg_wdata[c];

    dma_rx_chan_regs #(.DW(DW), .AMT_W(AMT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_c), .wr_ofs(ofs), .wdata(cfg_wdata),
      .upd_en(upd_c), .upd_ptr(rx_upd_ptr), .upd_cnt(rx_upd_count),
      .done_en(done_c), .armed_clr(clr_c),
      .buf_q(buf_a[c]), .busa_q(busa_a[c]), .amt_q(amt_a[c]),
      .ptr_q(ptr_a[c]), .cnt_q(cnt_a[c]), .armed_q(armed[c])
    );

    assign rx_buf_addr_o[c*DW +: DW]     = buf_a[c];
    assign rx_bus_addr_o[c*DW +: DW]     = busa_a[c];
    assign rx_amount_o[c*AMT_W +: AMT_W] = amt_a[c];
    assign rx_ptr_o[c*DW +: DW]          = ptr_a[c];
  end
  assign rx_armed_o = armed;

  logic [15:0] cfg_w;
  logic        tx_busy;

  dma_tx_ctrl_regs #(.DW(DW), .AMT_W(AMT_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr && win0), .wr_ofs(ofs), .wdata(cfg_wdata),
    .tx_done(tx_done),
    .tx_buf_q(tx_buf_addr_o), .tx_amt_q(tx_amount_o),
    .tx_cmd_q(tx_cmd_o), .tx_dest_q(tx_dest_o),
    .cfg_o(cfg_w), .busy_q(tx_busy), .start_q(tx_start_o)
  );

  logic [31:0]   irq_bits;
  logic [DW-1:0] unm_q;

  dma_irq_ctrl #(.DW(DW), .NCH(NCH), .CH_W(CH_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .done_valid(rx_done_valid), .done_chan(rx_done_chan),
    .unm_valid(unm_valid), .unm_addr(unm_addr),
    .clr_en(wr && win0 && (ofs == OFS_IRQ)), .clr_mask(cfg_wdata[31:0]),
    .rx_ie(cfg_w[CFG_RX_IE]), .unm_ie(cfg_w[CFG_UNM_IE]),
    .irq_bits(irq_bits), .unm_q(unm_q), .irq_o(irq_o)
  );

  logic [DW-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (win_ok) begin
      case (ofs)
        OFS_BUF:  rd_word = buf_a[win];
        OFS_BUSA: rd_word = busa_a[win];
        OFS_AMT:  rd_word = DW'(amt_a[win]);
        OFS_PTR:  rd_word = ptr_a[win];
        OFS_CNT:  rd_word = DW'(cnt_a[win]);
        default:  rd_word = '0;
      endcase
    end
    if (win0) begin
      case (ofs)
        OFS_CTRL:   rd_word = DW'({15'b0, tx_busy, cfg_w});
        OFS_ARMED:  rd_word = DW'(armed);
        OFS_IRQ:    rd_word = DW'(irq_bits);
        OFS_TXBUF:  rd_word = tx_buf_addr_o;
        OFS_TXAMT:  rd_word = DW'(tx_amount_o);
        OFS_TXCMD:  rd_word = tx_cmd_o;
        OFS_TXDEST: rd_word = tx_dest_o;
        OFS_UNM:    rd_word = unm_q;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_rdata <= '0;
    else if (cfg_cs && cfg_re) cfg_rdata <= rd_word;
  end
endmodule

// File: rtl/dma_cfg_regbank_chk.sv
module dma_cfg_regbank_chk #(
  parameter int DW     = 32,
  parameter int NCH    = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_cs,
  input logic              cfg_we,
  input logic              cfg_re,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DW-1:0]     cfg_rdata,
  input logic              rx_done_valid,
  input logic              unm_valid,
  input logic              tx_start_o,
  input logic              tx_busy,
  input logic              irq_o,
  input logic [NCH-1:0]    rx_armed_o,
  input logic [31:0]       irq_bits
);
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> !$past(tx_busy)); // R11
  AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> tx_busy); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_cs && cfg_re) |-> $stable(cfg_rdata)); // R3
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(rx_done_valid || unm_valid || (cfg_cs && cfg_we))); // R10
  AST_AMOUNT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cs && cfg_we && cfg_addr[3:0] == 4'd2)
      |=> rx_armed_o[$past(cfg_addr[ADDR_W-1:4])]); // R5
  AST_UNM_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    unm_valid |=> irq_bits[31]); // R9
endmodule

bind dma_cfg_regbank dma_cfg_regbank_chk #(.DW(DW), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cs(cfg_cs), .cfg_we(cfg_we), .cfg_re(cfg_re),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .rx_done_valid(rx_done_valid),
  .unm_valid(unm_valid), .tx_start_o(tx_start_o), .tx_busy(tx_busy),
  .irq_o(irq_o), .rx_armed_o(rx_armed_o), .irq_bits(irq_bits)
);

// File: tb/sim_dma_cfg_regbank.sv
`timescale 1ns/1ps
module sim_dma_cfg_regbank;
  localparam int DW = 32, AMT_W = 16, NCH = 8, CH_W = 3, AW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cs = 0, cfg_we = 0, cfg_re = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic irq_o;
  logic [NCH*DW-1:0] rx_buf_addr_o, rx_bus_addr_o, rx_ptr_o;
  logic [NCH*AMT_W-1:0] rx_amount_o;
  logic [NCH-1:0] rx_armed_o;
  logic rx_upd_valid = 0, rx_done_valid = 0, unm_valid = 0, tx_done = 0;
  logic [CH_W-1:0] rx_upd_chan = '0, rx_done_chan = '0;
  logic [DW-1:0] rx_upd_ptr = '0, unm_addr = '0;
  logic [AMT_W-1:0] rx_upd_count = '0;
  logic [DW-1:0] tx_buf_addr_o, tx_cmd_o, tx_dest_o;
  logic [AMT_W-1:0] tx_amount_o;
  logic tx_start_o;

  always #4 clk = ~clk;

  dma_cfg_regbank #(.DW(DW), .AMT_W(AMT_W), .NCH(NCH)) u0 (.*);

  int checks = 0, errors = 0;
  logic last_start;
  logic [31:0] rd;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_cs = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk); cfg_cs = 0; cfg_we = 0; last_start = tx_start_o;
  endtask

  task automatic cpu_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_cs = 1; cfg_re = 1; cfg_addr = a;
    @(posedge clk);
    @(negedge clk); cfg_cs = 0; cfg_re = 0; d = cfg_rdata;
  endtask

  task automatic pulse_done(input logic [CH_W-1:0] c);
    @(negedge clk); rx_done_valid = 1; rx_done_chan = c;
    @(posedge clk);
    @(negedge clk); rx_done_valid = 0;
  endtask

  // [39] write, [38:32] address, [31:0] write data or expected read
  localparam int NV = 27;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 7'h00, 32'h0000_1000}, {1'b0, 7'h00, 32'h0000_1000}, // R1 ch0 buffer
    {1'b1, 7'h31, 32'h0A0B_0C0D}, {1'b0, 7'h31, 32'h0A0B_0C0D}, // R1 ch3 remote
    {1'b1, 7'h72, 32'h0001_2345}, {1'b0, 7'h72, 32'h0000_2345}, // R12 amount mask
    {1'b1, 7'h73, 32'h0000_FFFF}, {1'b0, 7'h73, 32'h0000_0000}, // R4 pointer ro
    {1'b1, 7'h76, 32'h0000_0005}, {1'b0, 7'h76, 32'h0000_0000}, // R4 count ro
    {1'b1, 7'h0D, 32'h0000_DEAD}, {1'b0, 7'h0D, 32'h0000_0000}, // R2 unused
    {1'b1, 7'h24, 32'h0000_00FF}, {1'b0, 7'h24, 32'h0000_0000}, // R2 ch2 no ctrl
    {1'b1, 7'h08, 32'h0000_3000}, {1'b0, 7'h08, 32'h0000_3000}, // R12 tx buffer
    {1'b1, 7'h09, 32'h000A_BCDE}, {1'b0, 7'h09, 32'h0000_BCDE}, // R12 tx amount
    {1'b1, 7'h0A, 32'h0000_0055}, {1'b0, 7'h0A, 32'h0000_0055}, // R12 tx command
    {1'b1, 7'h0B, 32'h1234_5678}, {1'b0, 7'h0B, 32'h1234_5678}, // R12 tx dest
    {1'b1, 7'h0C, 32'h0000_0077}, {1'b0, 7'h0C, 32'h0000_0000}, // R4 unmatched ro
    {1'b1, 7'h3B, 32'h0000_0099}, {1'b0, 7'h3B, 32'h0000_0000}, // R2 ch3 no tx
    {1'b0, 7'h7F, 32'h0000_0000}                                // R2 ch7 top
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R13 reset state
    chk("R13 rdata", cfg_rdata, 0);
    chk("R13 irq_o", {31'b0, irq_o}, 0);
    chk("R13 armed", {24'b0, rx_armed_o}, 0);
    chk("R13 tx_start", {31'b0, tx_start_o}, 0);
    cpu_rd(7'h04, rd); chk("R13 ctrl", rd, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39]) cpu_wr(VEC[i][38:32], VEC[i][31:0]);
      else begin
        cpu_rd(VEC[i][38:32], rd);
        chk($sformatf("table %0d (R1/R2/R4/R12)", i), rd, VEC[i][31:0]);
      end
    end
    chk("R12 tx_buf port", tx_buf_addr_o, 32'h3000);
    chk("R12 tx_dest port", tx_dest_o, 32'h1234_5678);

    // R3 hold: idle cycles keep last read data
    repeat (3) @(negedge clk);
    chk("R3 rdata hold", cfg_rdata, 0);

    // R5 / R7 armed mask
    cpu_rd(7'h05, rd); chk("R5 ch7 armed", rd, 32'h80);
    cpu_wr(7'h05, 32'h80);
    cpu_rd(7'h05, rd); chk("R7 armed w1c", rd, 0);
    cpu_wr(7'h10, 32'h200);
    cpu_wr(7'h12, 32'h4);
    cpu_rd(7'h13, rd); chk("R5 pointer load", rd, 32'h200);
    cpu_rd(7'h05, rd); chk("R5 arm ch1", rd, 32'h2);
    chk("R5 armed port", {24'b0, rx_armed_o}, 32'h2);

    // R6 engine update
    @(negedge clk); rx_upd_valid = 1; rx_upd_chan = 1; rx_upd_ptr = 32'h204; rx_upd_count = 16'd1;
    @(posedge clk); @(negedge clk); rx_upd_valid = 0;
    cpu_rd(7'h13, rd); chk("R6 pointer update", rd, 32'h204);
    cpu_rd(7'h16, rd); chk("R6 count update", rd, 32'h1);
    // R6 collision: amount write wins
    @(negedge clk);
    cfg_cs = 1; cfg_we = 1; cfg_addr = 7'h12; cfg_wdata = 32'h4;
    rx_upd_valid = 1; rx_upd_chan = 1; rx_upd_ptr = 32'h999; rx_upd_count = 16'd9;
    @(posedge clk); @(negedge clk);
    cfg_cs = 0; cfg_we = 0; rx_upd_valid = 0;
    cpu_rd(7'h13, rd); chk("R6 collision pointer", rd, 32'h200);
    cpu_rd(7'h16, rd); chk("R6 collision count", rd, 0);

    // R7 done
    pulse_done(1);
    cpu_rd(7'h07, rd); chk("R7 done irq bit", rd, 32'h2);
    cpu_rd(7'h05, rd); chk("R7 done disarms", rd, 0);
    chk("R10 irq masked", {31'b0, irq_o}, 0);
    cpu_wr(7'h04, 32'h2);
    chk("R10 irq enabled", {31'b0, irq_o}, 1);
    cpu_wr(7'h07, 32'h2);
    cpu_rd(7'h07, rd); chk("R8 irq w1c", rd, 0);
    chk("R8 irq_o low", {31'b0, irq_o}, 0);
    // R8 set wins over clear
    pulse_done(1);
    @(negedge clk);
    cfg_cs = 1; cfg_we = 1; cfg_addr = 7'h07; cfg_wdata = 32'h2;
    rx_done_valid = 1; rx_done_chan = 1;
    @(posedge clk); @(negedge clk);
    cfg_cs = 0; cfg_we = 0; rx_done_valid = 0;
    cpu_rd(7'h07, rd); chk("R8 set wins", rd, 32'h2);
    cpu_wr(7'h07, 32'h2);

    // R9 unmatched
    @(negedge clk); unm_valid = 1; unm_addr = 32'hABCD;
    @(posedge clk); @(negedge clk); unm_valid = 0;
    cpu_rd(7'h0C, rd); chk("R9 unmatched addr", rd, 32'hABCD);
    cpu_rd(7'h07, rd); chk("R9 irq bit31", rd, 32'h8000_0000);
    chk("R10 unm masked", {31'b0, irq_o}, 0);
    cpu_wr(7'h04, 32'h6);
    chk("R10 unm enabled", {31'b0, irq_o}, 1);
    cpu_wr(7'h07, 32'h8000_0000);
    chk("R10 unm cleared", {31'b0, irq_o}, 0);

    // R11 transmit start
    cpu_wr(7'h04, 32'h7);
    chk("R11 start pulse", {31'b0, last_start}, 1);
    cpu_rd(7'h04, rd); chk("R11 busy status", rd, 32'h0001_0006);
    chk("R11 pulse one cycle", {31'b0, tx_start_o}, 0);
    cpu_wr(7'h04, 32'h7);
    chk("R11 start while busy", {31'b0, last_start}, 0);
    @(negedge clk); tx_done = 1; @(posedge clk); @(negedge clk); tx_done = 0;
    cpu_rd(7'h04, rd); chk("R11 idle status", rd, 32'h0000_0006);
    cpu_wr(7'h04, 32'h7);
    chk("R11 restart", {31'b0, last_start}, 1);

    summary();
  end
endmodule